// File: doc/BRIEF.md
# Multi-Format Stereo Serial PCM Port

This block joins an external stereo serial PCM link to a processing core. The link brings a bit clock, an active-low word clock and a serial data line into the block, and the block drives one serial data line back out. The block runs on its own system clock and oversamples both link clocks through a synchronizer. It detects bit-clock edges and counts bit positions within each half frame. Every received left/right pair goes to the core as two parallel 20-bit words with a one-cycle valid strobe. Two parallel words from the core are serialized back out in the same frame layout.

A 2-bit format code selects one of four layouts. Three use a 48-bit-clock frame (24 clocks per channel) and place 16, 18 or 20 data bits at the end of each half. The fourth uses a 64-bit-clock frame (32 clocks per channel) and places 16 bits at the start of each half, one clock after the word-clock edge. The bit counter restarts at every word-clock edge, so a spurious or lost bit-clock edge damages only the frame where it happens.

Control is split between two small state machines. The frame tracker has the states ST_SYNC_WAIT, ST_LEFT_HALF and ST_RIGHT_HALF. It leaves ST_SYNC_WAIT only on a falling word clock, which enters ST_LEFT_HALF. After that, a rising word clock moves it to ST_RIGHT_HALF and a falling word clock moves it back to ST_LEFT_HALF. The transmitter has the states TX_IDLE and TX_RUN. It moves from TX_IDLE to TX_RUN at the first falling bit-clock edge that starts a left half, and it stays in TX_RUN until reset.

Top module: `serial_audio_port`

## Requirements
- R1: `wclk_n_i` low marks the left half and high marks the right half, and a frame starts with the left half. Bit position 0 of a half is the first rising `bclk_i` edge after the word clock changes level, and each further rising edge adds one to the position.
- R2: Format code 00 uses 24 bit clocks per half, and the 16 data bits sit at positions 8..23, MSB first.
- R3: Format code 01 uses 24 bit clocks per half, and the 18 data bits sit at positions 6..23, MSB first. The transmitter sends the two lowest of these bits (positions 22 and 23) as zero.
- R4: Format code 10 uses 24 bit clocks per half, and the 20 data bits sit at positions 4..23, MSB first. The transmitter sends the four lowest of these bits (positions 20..23) as zero.
- R5: Format code 11 uses 32 bit clocks per half, and the 16 data bits sit at positions 1..16, MSB first.
- R6: `sdata_i` is sampled on the rising bit-clock edge. After the last data bit of the right half, `rx_valid_o` pulses high for exactly one system clock. In that cycle `rx_left_o` and `rx_right_o` hold the received words, sign-extended from the slot width to 20 bits.
- R7: `sdata_o` changes only after a falling bit-clock edge and is 0 outside the data slot. The transmitted words are the low slot-width bits of `tx_left_i`/`tx_right_i`, captured at the falling bit-clock edge that starts each left half.
- R8: After reset, `rx_valid_o`, `rx_left_o`, `rx_right_o` and `sdata_o` are 0. They stay 0 until the first falling word-clock edge, whatever happens on the bit clock.
- R9: An extra or a missing bit-clock pulse inside a left half leaves the right half of that frame, and every later frame, received and transmitted correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bit clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fmt_i | input | 2 | Frame layout code (R2..R5) |
| bclk_i | input | 1 | External serial bit clock |
| wclk_n_i | input | 1 | External word clock, low for the left channel |
| sdata_i | input | 1 | Serial PCM data in |
| sdata_o | output | 1 | Serial PCM data out |
| tx_left_i | input | 20 | Left word to transmit |
| tx_right_i | input | 20 | Right word to transmit |
| rx_left_o | output | 20 | Received left word, sign-extended |
| rx_right_o | output | 20 | Received right word, sign-extended |
| rx_valid_o | output | 1 | One-cycle strobe for a new received pair |

## Verification
The bench builds the block with `SYNC_STAGES` = 2. It drives the bit clock at one twelfth of the system clock, which leaves enough margin after the synchronizer delay to sample the output before each rising edge. This ratio keeps a 64-clock frame under 800 system cycles. That in turn allows directed full-scale frames in all four layouts, a randomized run that changes layout between frames, and frames with an inserted or a removed bit-clock pulse, all within a short run.

// File: rtl/sap_pkg.sv
package sap_pkg;

    localparam int SAMPLE_W = 20;
    localparam int POS_W    = 6;

    typedef logic [SAMPLE_W-1:0] sample_t;
    typedef logic [POS_W-1:0]    pos_t;

    typedef enum logic [1:0] {
        FMT_48_16 = 2'b00,
        FMT_48_18 = 2'b01,
        FMT_48_20 = 2'b10,
        FMT_64_16 = 2'b11
    } fmt_e;

    typedef enum logic [1:0] {
        ST_SYNC_WAIT  = 2'd0,
        ST_LEFT_HALF  = 2'd1,
        ST_RIGHT_HALF = 2'd2
    } half_e;

    typedef enum logic {
        TX_IDLE = 1'b0,
        TX_RUN  = 1'b1
    } tx_e;

    // first position of the data slot in a half frame
    function automatic pos_t first_pos(fmt_e f);
        pos_t r;
        unique case (f)
            FMT_48_16: r = 6'd8;
            FMT_48_18: r = 6'd6;
            FMT_48_20: r = 6'd4;
            FMT_64_16: r = 6'd1;
        endcase
        return r;
    endfunction

    // position carrying the slot LSB
    function automatic pos_t last_pos(fmt_e f);
        return (f == FMT_64_16) ? 6'd16 : 6'd23;
    endfunction

    // low slot bits forced to zero on transmit
    function automatic pos_t pad_bits(fmt_e f);
        pos_t r;
        unique case (f)
            FMT_48_18: r = 6'd2;
            FMT_48_20: r = 6'd4;
            default:   r = 6'd0;
        endcase
        return r;
    endfunction

    function automatic sample_t sext_word(sample_t s, fmt_e f);
        sample_t r;
        unique case (f)
            FMT_48_18: r = {{2{s[17]}}, s[17:0]};
            FMT_48_20: r = s;
            default:   r = {{4{s[15]}}, s[15:0]};
        endcase
        return r;
    endfunction

endpackage

// File: rtl/sap_sync.sv
module sap_sync #(
    parameter int         W       = 3,
    parameter int         STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    localparam int CHAIN_W = W * STAGES;

    logic [CHAIN_W-1:0] chain;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain <= RST_VAL;
                else        chain <= d;
            end
        end else begin : g_multi
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain <= {STAGES{RST_VAL}};
                else        chain <= {chain[CHAIN_W-W-1:0], d};
            end
        end
    endgenerate

    assign q = chain[CHAIN_W-1 -: W];
endmodule

// File: rtl/sap_frame_ctl.sv
module sap_frame_ctl
    import sap_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  bclk_s,
    input  logic  wclk_s,
    output logic  rise_p,
    output logic  fall_p,
    output pos_t  pos_q,
    output logic  lvl_q,
    output half_e state_q
);
    logic  bclk_d;
    logic  wedge;
    half_e state_d;
    pos_t  pos_d;
    logic  lvl_d;

    assign rise_p = bclk_s & ~bclk_d;
    assign fall_p = ~bclk_s & bclk_d;
    assign wedge  = wclk_s ^ lvl_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_SYNC_WAIT;
            pos_q   <= '0;
            lvl_q   <= 1'b1;
            bclk_d  <= 1'b0;
        end else begin
            state_q <= state_d;
            pos_q   <= pos_d;
            lvl_q   <= lvl_d;
            bclk_d  <= bclk_s;
        end
    end

    // next state and position counter
    always_comb begin
        state_d = state_q;
        pos_d   = pos_q;
        lvl_d   = lvl_q;
        if (rise_p) begin
            lvl_d = wclk_s;
            if (wedge) begin
                pos_d = '0;
                unique case (state_q)
                    ST_SYNC_WAIT:  state_d = wclk_s ? ST_SYNC_WAIT : ST_LEFT_HALF;
                    ST_LEFT_HALF:  state_d = wclk_s ? ST_RIGHT_HALF : ST_LEFT_HALF;
                    ST_RIGHT_HALF: state_d = wclk_s ? ST_RIGHT_HALF : ST_LEFT_HALF;
                    default:       state_d = ST_SYNC_WAIT;
                endcase
            end else if (pos_q != '1) begin
                pos_d = pos_q + 6'd1;
            end
        end
    end

    // R1: a word-clock change restarts the position count
    a_r1_pos_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (rise_p && (wclk_s != lvl_q)) |=> (pos_q == '0));

    // R1: within a half, each rising edge advances the position
    a_r1_pos_advance: assert property (@(posedge clk) disable iff (!rst_n)
        (rise_p && (wclk_s == lvl_q) && (pos_q != '1)) |=> (pos_q == $past(pos_q) + 6'd1));

    // R8: leaving the wait state always goes to the left half first
    a_r8_left_first: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SYNC_WAIT) |=> (state_q != ST_RIGHT_HALF));
endmodule

// File: rtl/sap_rx.sv
module sap_rx
    import sap_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  fmt_e    fmt,
    input  logic    rise_p,
    input  logic    sdata_s,
    input  pos_t    pos_q,
    input  half_e   state_q,
    output sample_t rx_left_o,
    output sample_t rx_right_o,
    output logic    rx_valid_o
);
    sample_t sreg;
    sample_t left_hold;
    sample_t word_x;
    logic    rise_d;
    logic    at_end;

    assign at_end = rise_d && (pos_q == last_pos(fmt));
    assign word_x = sext_word(sreg, fmt);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sreg       <= '0;
            left_hold  <= '0;
            rise_d     <= 1'b0;
            rx_left_o  <= '0;
            rx_right_o <= '0;
            rx_valid_o <= 1'b0;
        end else begin
            rise_d     <= rise_p;
            rx_valid_o <= 1'b0;
            if (rise_p) sreg <= {sreg[SAMPLE_W-2:0], sdata_s};
            if (at_end) begin
                unique case (state_q)
                    ST_LEFT_HALF:  left_hold <= word_x;
                    ST_RIGHT_HALF: begin
                        rx_left_o  <= left_hold;
                        rx_right_o <= word_x;
                        rx_valid_o <= 1'b1;
                    end
                    default: ;
                endcase
            end
        end
    end

    // R6: the valid strobe lasts one cycle
    a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid_o |=> !rx_valid_o);

    // R6: a pair is delivered only at the end of a right half
    a_r6_after_right: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid_o |-> ($past(state_q) == ST_RIGHT_HALF));

    // R6: 16-bit layouts deliver a sign-extended right word
    a_r6_sext16: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid_o && (($past(fmt) == FMT_48_16) || ($past(fmt) == FMT_64_16)))
        |-> ((rx_right_o[19:15] == 5'b00000) || (rx_right_o[19:15] == 5'b11111)));
endmodule

// File: rtl/sap_tx.sv
module sap_tx
    import sap_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  fmt_e    fmt,
    input  logic    fall_p,
    input  logic    wclk_s,
    input  logic    lvl_q,
    input  pos_t    pos_q,
    input  sample_t tx_left_i,
    input  sample_t tx_right_i,
    output logic    sdata_o
);
    tx_e     tx_q, tx_d;
    sample_t hold_l, hold_r, word;
    pos_t    npos, bidx;
    logic    in_slot, frame_start, bit_v;

    always_comb begin
        npos        = (wclk_s != lvl_q) ? '0 : ((pos_q == '1) ? pos_q : pos_q + 6'd1);
        frame_start = fall_p && (wclk_s != lvl_q) && !wclk_s;
        in_slot     = (npos >= first_pos(fmt)) && (npos <= last_pos(fmt));
        bidx        = last_pos(fmt) - npos;
        word        = wclk_s ? hold_r : hold_l;
        bit_v       = in_slot && (bidx >= pad_bits(fmt)) && word[bidx[4:0]];
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tx_q <= TX_IDLE;
        else        tx_q <= tx_d;
    end

    always_comb begin
        tx_d = tx_q;
        unique case (tx_q)
            TX_IDLE: if (frame_start) tx_d = TX_RUN;
            TX_RUN:  tx_d = TX_RUN;
        endcase
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_l  <= '0;
            hold_r  <= '0;
            sdata_o <= 1'b0;
        end else begin
            if (frame_start) begin
                hold_l <= tx_left_i;
                hold_r <= tx_right_i;
            end
            if (fall_p) sdata_o <= (tx_q == TX_RUN) ? bit_v : 1'b0;
        end
    end

    // R7: the line moves only after a falling bit-clock edge
    a_r7_change_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sdata_o) |-> $past(fall_p));

    // R7: nothing is driven outside the slot
    a_r7_zero_outside: assert property (@(posedge clk) disable iff (!rst_n)
        (fall_p && ((npos < first_pos(fmt)) || (npos > last_pos(fmt)))) |=> !sdata_o);

    // R3: two pad bits at the end of the 18-bit slot
    a_r3_pad_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (fall_p && (fmt == FMT_48_18) && (npos >= 6'd22) && (npos <= 6'd23)) |=> !sdata_o);

    // R4: four pad bits at the end of the 20-bit slot
    a_r4_pad_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (fall_p && (fmt == FMT_48_20) && (npos >= 6'd20) && (npos <= 6'd23)) |=> !sdata_o);

    // R8: the line is quiet until the first frame start
    a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_q == TX_IDLE) |-> !sdata_o);
endmodule

// File: rtl/serial_audio_port.sv
module serial_audio_port
    import sap_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [1:0]  fmt_i,
    input  logic        bclk_i,
    input  logic        wclk_n_i,
    input  logic        sdata_i,
    output logic        sdata_o,
    input  logic [19:0] tx_left_i,
    input  logic [19:0] tx_right_i,
    output logic [19:0] rx_left_o,
    output logic [19:0] rx_right_o,
    output logic        rx_valid_o
);
    localparam int SYNC_W = 3;

    logic [SYNC_W-1:0] sync_q;
    logic  bclk_s, wclk_s, sdata_s;
    logic  rise_p, fall_p, lvl_q;
    pos_t  pos_q;
    half_e state_q;
    fmt_e  fmt;

    assign fmt = fmt_e'(fmt_i);

    sap_sync #(
        .W       (SYNC_W),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (3'b010)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({bclk_i, wclk_n_i, sdata_i}),
        .q     (sync_q)
    );

    assign {bclk_s, wclk_s, sdata_s} = sync_q;

    sap_frame_ctl u_frame (
        .clk     (clk),
        .rst_n   (rst_n),
        .bclk_s  (bclk_s),
        .wclk_s  (wclk_s),
        .rise_p  (rise_p),
        .fall_p  (fall_p),
        .pos_q   (pos_q),
        .lvl_q   (lvl_q),
        .state_q (state_q)
    );

    sap_rx u_rx (
        .clk        (clk),
        .rst_n      (rst_n),
        .fmt        (fmt),
        .rise_p     (rise_p),
        .sdata_s    (sdata_s),
        .pos_q      (pos_q),
        .state_q    (state_q),
        .rx_left_o  (rx_left_o),
        .rx_right_o (rx_right_o),
        .rx_valid_o (rx_valid_o)
    );

    sap_tx u_tx (
        .clk        (clk),
        .rst_n      (rst_n),
        .fmt        (fmt),
        .fall_p     (fall_p),
        .wclk_s     (wclk_s),
        .lvl_q      (lvl_q),
        .pos_q      (pos_q),
        .tx_left_i  (tx_left_i),
        .tx_right_i (tx_right_i),
        .sdata_o    (sdata_o)
    );
endmodule

// File: tb/sim_serial_audio_port.sv
`timescale 1ns/1ps
module sim_serial_audio_port;
    localparam int HALF_BIT = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  fmt = 2'b00;
    logic        bclk = 1'b0, wclk = 1'b1, sdin = 1'b0;
    logic        sdout;
    logic [19:0] tx_l = '0, tx_r = '0;
    logic [19:0] rx_l, rx_r;
    logic        rx_v;

    int nchk = 0, nerr = 0, vcnt = 0;
    logic [19:0] got_l = '0, got_r = '0;
    bit done = 0;
    int unsigned seed_v;

    always #2.5 clk = ~clk;

    serial_audio_port u0 (
        .clk(clk), .rst_n(rst_n), .fmt_i(fmt), .bclk_i(bclk), .wclk_n_i(wclk),
        .sdata_i(sdin), .sdata_o(sdout), .tx_left_i(tx_l), .tx_right_i(tx_r),
        .rx_left_o(rx_l), .rx_right_o(rx_r), .rx_valid_o(rx_v)
    );

    always @(negedge clk) if (rx_v) begin
        vcnt++;
        got_l = rx_l;
        got_r = rx_r;
    end

    task automatic check(input bit ok, input string msg);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s", msg);
        end
    endtask

    function automatic int slot_n(logic [1:0] f);
        return (f == 2'b01) ? 18 : (f == 2'b10) ? 20 : 16;
    endfunction

    function automatic int pad_n(logic [1:0] f);
        return (f == 2'b01) ? 2 : (f == 2'b10) ? 4 : 0;
    endfunction

    function automatic int half_len(logic [1:0] f);
        return (f == 2'b11) ? 32 : 24;
    endfunction

    function automatic string fmt_tag(logic [1:0] f);
        case (f)
            2'b00: return "R2";
            2'b01: return "R3";
            2'b10: return "R4";
            default: return "R5";
        endcase
    endfunction

    // bit index of the word carried at position p, or -1 outside the slot
    function automatic int slot_index(logic [1:0] f, int p);
        int n;
        if (f == 2'b11) return (p >= 1 && p <= 16) ? 16 - p : -1;
        n = slot_n(f);
        return (p >= 24 - n && p <= 23) ? 23 - p : -1;
    endfunction

    function automatic logic [19:0] exp_rx(logic [1:0] f, logic [19:0] w);
        case (slot_n(f))
            18: return {{2{w[17]}}, w[17:0]};
            20: return w;
            default: return {{4{w[15]}}, w[15:0]};
        endcase
    endfunction

    function automatic logic exp_tx(logic [1:0] f, logic [19:0] w, int p);
        int b;
        b = slot_index(f, p);
        if (b < 0 || b < pad_n(f)) return 1'b0;
        return w[b];
    endfunction

    // mode: 0 plain, 1 extra pulse at left position 2, 2 missing pulse there
    // chk: 0 none, 1 full, 2 right-channel receive only
    task automatic send_frame(input logic [1:0] f, input logic [19:0] rl, rr, tl, tr,
                              input int mode, input int chk);
        int cnt0, txbad, stbad, bad_p, bad_h;
        logic lowv, expv, bad_got, bad_exp;
        string tg;
        fmt = f; tx_l = tl; tx_r = tr;
        cnt0 = vcnt; txbad = 0; stbad = 0;
        bad_p = 0; bad_h = 0; bad_got = 0; bad_exp = 0;
        tg = fmt_tag(f);
        for (int h = 0; h < 2; h++) begin
            for (int p = 0; p < half_len(f); p++) begin
                int b;
                b = slot_index(f, p);
                bclk = 1'b0;
                wclk = h[0];
                sdin = (b >= 0) ? (h == 0 ? rl[b] : rr[b]) : 1'($urandom & 1);
                repeat (HALF_BIT) @(negedge clk);
                lowv = sdout;
                expv = exp_tx(f, h == 0 ? tl : tr, p);
                if (lowv !== expv && txbad == 0) begin
                    bad_p = p; bad_h = h; bad_got = lowv; bad_exp = expv;
                end
                if (lowv !== expv) txbad++;
                bclk = (mode == 2 && h == 0 && p == 2) ? 1'b0 : 1'b1;
                repeat (HALF_BIT) @(negedge clk);
                if (sdout !== lowv) stbad++;
                if (mode == 1 && h == 0 && p == 2) begin
                    bclk = 1'b0; repeat (3) @(negedge clk);
                    bclk = 1'b1; repeat (3) @(negedge clk);
                end
            end
        end
        if (chk == 1) begin
            check(vcnt == cnt0 + 1, $sformatf("R6 %s strobe count got %0d exp %0d", tg, vcnt - cnt0, 1));
            check(got_l == exp_rx(f, rl) && got_r == exp_rx(f, rr),
                  $sformatf("R1 R6 %s rx got %h/%h exp %h/%h", tg, got_l, got_r, exp_rx(f, rl), exp_rx(f, rr)));
            check(txbad == 0, $sformatf("R7 %s tx half %0d pos %0d got %b exp %b (%0d bad bits)",
                  tg, bad_h, bad_p, bad_got, bad_exp, txbad));
            check(stbad == 0, $sformatf("R7 %s output moved while bit clock high: got %0d exp 0", tg, stbad));
        end else if (chk == 2) begin
            check(got_r == exp_rx(f, rr),
                  $sformatf("R9 %s right after glitch got %h exp %h", tg, got_r, exp_rx(f, rr)));
        end
    endtask

    initial begin
        int quiet_bad;
        seed_v = $urandom(32'd90125);
        repeat (5) @(negedge clk);
        check(rx_v === 1'b0 && rx_l === 20'h0 && rx_r === 20'h0 && sdout === 1'b0,
              $sformatf("R8 reset state got v=%b l=%h r=%h o=%b exp all zero", rx_v, rx_l, rx_r, sdout));
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check(rx_v === 1'b0 && sdout === 1'b0, $sformatf("R8 after reset got v=%b o=%b exp 0", rx_v, sdout));

        // bit clock runs with the word clock held high: nothing may happen
        quiet_bad = 0;
        for (int i = 0; i < 10; i++) begin
            bclk = 1'b0; sdin = 1'($urandom & 1);
            repeat (HALF_BIT) @(negedge clk);
            if (sdout !== 1'b0) quiet_bad++;
            bclk = 1'b1;
            repeat (HALF_BIT) @(negedge clk);
            if (sdout !== 1'b0) quiet_bad++;
        end
        check(vcnt == 0 && quiet_bad == 0,
              $sformatf("R8 before first frame got strobes=%0d busy=%0d exp 0/0", vcnt, quiet_bad));

        // directed full-scale corners in every layout
        send_frame(2'b00, 20'h07FFF, 20'h08000, 20'hFFFFF, 20'h0A5A5, 0, 1);
        send_frame(2'b01, 20'h20000, 20'h1FFFF, 20'hFFFFF, 20'h3C3C3, 0, 1);
        send_frame(2'b10, 20'h80000, 20'h7FFFF, 20'hFFFFF, 20'h5A5A5, 0, 1);
        send_frame(2'b11, 20'h08000, 20'h07FFF, 20'hFFFFF, 20'h12345, 0, 1);
        send_frame(2'b01, 20'h00003, 20'hFFFFC, 20'h00003, 20'h0000F, 0, 1);
        send_frame(2'b10, 20'h0000F, 20'h00001, 20'h0000F, 20'h80000, 0, 1);

        // random words, layout changed between frames
        for (int i = 0; i < 20; i++) begin
            logic [1:0] f;
            f = 2'($urandom % 4);
            send_frame(f, 20'($urandom), 20'($urandom), 20'($urandom), 20'($urandom), 0, 1);
        end

        // R9: stray and missing bit-clock pulses, then a clean frame
        send_frame(2'b00, 20'h01234, 20'h0BEEF, 20'h0F0F0, 20'h00FF0, 1, 2);
        send_frame(2'b00, 20'h04321, 20'h0CAFE, 20'h01111, 20'h02222, 0, 1);
        send_frame(2'b11, 20'h05555, 20'h0AAAA, 20'h03333, 20'h04444, 2, 2);
        send_frame(2'b11, 20'h06666, 20'h09999, 20'h0ABCD, 20'h0DCBA, 0, 1);
        send_frame(2'b10, 20'h13579, 20'h86420, 20'hCAFE5, 20'h5EFAC, 1, 2);
        send_frame(2'b10, 20'h2468A, 20'hFEDCB, 20'h77777, 20'h88888, 0, 1);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            nchk++;
            nerr++;
            $display("FAIL watchdog expired: got hung run, exp completion");
            $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
            $finish;
        end
    end
endmodule